// File: doc/BRIEF.md
# Interleaved Converter Mismatch Corrector

This block follows a time-interleaved analog-to-digital converter built from several sub-converters that sample in turn. Each clock it accepts at most one sample, tagged with the index of the sub-converter that produced it. For each sub-converter it learns a DC offset and an amplitude from that sub-converter's own samples, collected in windows of 2^WIN_LOG samples per channel. Every sample has its channel's offset estimate subtracted. The result is then multiplied by a gain factor that brings the channel's amplitude to that of channel 0, which serves as the reference.

Estimation runs in one of two modes. In one-shot mode the block calibrates after reset, or after a recalibrate pulse, and then freezes its estimates. In continuous mode it keeps refreshing them, window after window, during normal traffic. Gain factors come from a shared sequential divider, so a new amplitude takes effect a few tens of cycles after its window closes. The corrected sample keeps its channel tag and leaves after a fixed two-cycle latency, saturated to the input's signed range. Two-way and four-way interleaving are supported through NUM_CH.

Top module: `ilv_mismatch_corrector`

## Requirements
- R1: After reset every channel has offset 0 and gain 1.0, so until a window completes each valid sample appears unchanged at the output.
- R2: A sample accepted on a clock edge appears at the output two edges later with out_valid high and the same channel tag. out_valid is low for every cycle whose input slot two edges earlier had in_valid low.
- R3: A channel's offset estimate is the floor of the mean of its last 2^WIN_LOG accepted samples. It changes only on the edge that accepts the last sample of a window.
- R4: A channel's amplitude estimate is the floor of the mean of |sample − offset estimate| over the same window, using the offset estimate held while that window was collected.
- R5: The gain for channel 0 is 0x8000, which is 1.0 in unsigned Q1.15. The gain for channel c ≥ 1 is floor(amp0·2^15/ampc); it is 0xFFFF when amp0 ≥ 2·ampc and 0x8000 when ampc is 0. It takes effect within 20·NUM_CH cycles of either amplitude changing.
- R6: The output is floor((sample − offset)·gain / 2^15), so it rounds toward minus infinity.
- R7: The output saturates to [−2^(DW−1), 2^(DW−1)−1].
- R8: With mode_cont low, estimation stops once every channel has completed at least two windows since reset or the last recalibrate pulse. The estimates then stay constant whatever samples arrive.
- R9: A recal pulse discards partial windows and restarts one-shot calibration, and the new estimates then replace the old ones.
- R10: With mode_cont high, estimation runs continuously, even after a one-shot freeze, and the estimates follow each completed window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | $clog2(NUM_CH) | Sub-converter index of the sample |
| in_data | input | DW | Two's-complement sample |
| mode_cont | input | 1 | 1: continuous estimation, 0: one-shot then freeze |
| recal | input | 1 | One-cycle pulse that restarts calibration |
| out_valid | output | 1 | Corrected sample present |
| out_ch | output | $clog2(NUM_CH) | Channel tag of the corrected sample |
| out_data | output | DW | Corrected, saturated two's-complement sample |

## Verification
On every cycle the embedded properties check several things. The output valid and tag follow the internal stage by exactly one cycle. Estimates move only when their channel accepts a sample, and at most one window closes per cycle. Each quotient the divider writes lies within one unit of the exact ratio. Frozen estimates do not move. The arithmetic result itself can only be shown by the bench scenarios: floor rounding, saturation, the gain clamp, freezing, recalibration and the moment a continuous window takes effect. There, known offsets and amplitudes are fed per channel and the corrected samples are compared against values derived from the requirements.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam logic [GAIN_W-1:0] GAIN_ONE = 16'h8000;
  localparam logic [GAIN_W-1:0] GAIN_TOP = 16'hFFFF;
endpackage

// File: rtl/ilv_chan_stats.sv
module ilv_chan_stats #(
  parameter int DW      = 12,
  parameter int WIN_LOG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic                 clr,
  input  logic [DW-1:0]        smp_x,
  output logic [DW-1:0]        off_est,
  output logic [DW-1:0]        amp_est,
  output logic                 win_done
);
  localparam int ACC_W = DW + WIN_LOG;

  logic signed [ACC_W-1:0] sum_q, sum_d, sum_nx;
  logic [ACC_W-1:0]        asum_q, asum_d, asum_nx;
  logic [WIN_LOG-1:0]      cnt_q, cnt_d;
  logic [DW-1:0]           off_q, off_d, amp_q, amp_d;
  logic signed [DW:0]      diff;
  logic [DW:0]             mag;
  logic                    last;

  always_comb begin
    diff    = $signed({smp_x[DW-1], smp_x}) - $signed({off_q[DW-1], off_q});
    mag     = diff[DW] ? (-diff) : diff;
    sum_nx  = sum_q + $signed({{WIN_LOG{smp_x[DW-1]}}, smp_x});
    asum_nx = asum_q + {{(WIN_LOG-1){1'b0}}, mag};
    last    = &cnt_q;
    sum_d   = sum_q;
    asum_d  = asum_q;
    cnt_d   = cnt_q;
    off_d   = off_q;
    amp_d   = amp_q;
    win_done = 1'b0;
    if (clr) begin
      sum_d  = '0;
      asum_d = '0;
      cnt_d  = '0;
    end else if (smp_en) begin
      if (last) begin
        off_d    = sum_nx[ACC_W-1:WIN_LOG];
        amp_d    = asum_nx[ACC_W-1:WIN_LOG];
        sum_d    = '0;
        asum_d   = '0;
        cnt_d    = '0;
        win_done = 1'b1;
      end else begin
        sum_d  = sum_nx;
        asum_d = asum_nx;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      asum_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
      amp_q  <= '0;
    end else begin
      sum_q  <= sum_d;
      asum_q <= asum_d;
      cnt_q  <= cnt_d;
      off_q  <= off_d;
      amp_q  <= amp_d;
    end
  end

  assign off_est = off_q;
  assign amp_est = amp_q;

  // R3: estimates move only on an accepted sample of this channel
  p_est_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en && !clr) |=> ($stable(off_q) && $stable(amp_q)));
endmodule

// File: rtl/ilv_gain_solver.sv
module ilv_gain_solver
  import ilv_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CH-1:0][DW-1:0]       amp_bus,
  input  logic [NUM_CH-1:0]               amp_upd,
  output logic [NUM_CH-1:0][GAIN_W-1:0]   gain_bus
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:1]              pend_q, pend_d;
  logic                           busy_q, busy_d;
  logic [CW-1:0]                  sel_q, sel_d, pick_c;
  logic [3:0]                     cnt_q, cnt_d;
  logic [DW:0]                    rem_q, rem_d, rem_sub, rem_sh;
  logic [GAIN_W-1:0]              quo_q, quo_d, quo_nx;
  logic [DW-1:0]                  num_q, num_d, den_q, den_d, num_w, den_w;
  logic [NUM_CH-1:0][GAIN_W-1:0]  gain_q, gain_d;
  logic                           found, start, ge, fin;

  always_comb begin
    found  = 1'b0;
    pick_c = '0;
    for (int c = NUM_CH - 1; c >= 1; c--) begin
      if (pend_q[c]) begin
        found  = 1'b1;
        pick_c = CW'(c);
      end
    end
    start   = !busy_q && found;
    num_w   = amp_bus[0];
    den_w   = amp_bus[pick_c];
    ge      = rem_q >= {1'b0, den_q};
    rem_sub = ge ? (rem_q - {1'b0, den_q}) : rem_q;
    rem_sh  = rem_sub << 1;
    quo_nx  = {quo_q[GAIN_W-2:0], ge};
    fin     = busy_q && (cnt_q == 4'd0);

    for (int c = 1; c < NUM_CH; c++) begin
      pend_d[c] = (pend_q[c] && !(start && (pick_c == CW'(c)))) || amp_upd[c] || amp_upd[0];
    end

    busy_d = busy_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    num_d  = num_q;
    den_d  = den_q;
    gain_d = gain_q;

    if (start) begin
      sel_d = pick_c;
      num_d = num_w;
      den_d = den_w;
      if (den_w == '0) begin
        gain_d[pick_c] = GAIN_ONE;
      end else if ({1'b0, num_w} >= {den_w, 1'b0}) begin
        gain_d[pick_c] = GAIN_TOP;
      end else begin
        busy_d = 1'b1;
        rem_d  = {1'b0, num_w};
        quo_d  = '0;
        cnt_d  = 4'd15;
      end
    end
    if (busy_q) begin
      rem_d = rem_sh;
      quo_d = quo_nx;
      cnt_d = cnt_q - 4'd1;
      if (fin) begin
        busy_d        = 1'b0;
        gain_d[sel_q] = quo_nx;
      end
    end
    gain_d[0] = GAIN_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      sel_q  <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      gain_q <= {NUM_CH{GAIN_ONE}};
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      num_q  <= num_d;
      den_q  <= den_d;
      gain_q <= gain_d;
    end
  end

  assign gain_bus = gain_q;

  // R5: a finished quotient lies within one unit of amp0*2^15/ampc
  p_quotient_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((64'(quo_nx) * 64'(den_q) <= (64'(num_q) << 15)) &&
             ((64'(quo_nx) + 64'd1) * 64'(den_q) > (64'(num_q) << 15))));
endmodule

// File: rtl/ilv_corr_path.sv
module ilv_corr_path
  import ilv_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [$clog2(NUM_CH)-1:0]       in_ch,
  input  logic [DW-1:0]                   in_data,
  input  logic [NUM_CH-1:0][DW-1:0]       off_bus,
  input  logic [NUM_CH-1:0][GAIN_W-1:0]   gain_bus,
  output logic                            out_valid,
  output logic [$clog2(NUM_CH)-1:0]       out_ch,
  output logic [DW-1:0]                   out_data
);
  localparam int CW = $clog2(NUM_CH);
  localparam int PW = DW + 1 + GAIN_W + 1;

  logic                    a_vld_q, o_vld_q;
  logic [CW-1:0]           a_ch_q, o_ch_q;
  logic signed [DW:0]      a_diff_q, diff_w;
  logic [GAIN_W-1:0]       a_gain_q;
  logic [DW-1:0]           off_w, o_data_q, sat_w;
  logic signed [PW-1:0]    prod, scaled;
  logic                    in_range;

  always_comb begin
    off_w    = off_bus[in_ch];
    diff_w   = $signed({in_data[DW-1], in_data}) - $signed({off_w[DW-1], off_w});
    prod     = a_diff_q * $signed({1'b0, a_gain_q});
    scaled   = prod >>> GAIN_FRAC;
    in_range = (&scaled[PW-1:DW-1]) || !(|scaled[PW-1:DW-1]);
    if (in_range)
      sat_w = scaled[DW-1:0];
    else if (scaled[PW-1])
      sat_w = {1'b1, {(DW-1){1'b0}}};
    else
      sat_w = {1'b0, {(DW-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q  <= 1'b0;
      a_ch_q   <= '0;
      a_diff_q <= '0;
      a_gain_q <= '0;
    end else begin
      a_vld_q <= in_valid;
      if (in_valid) begin
        a_ch_q   <= in_ch;
        a_diff_q <= diff_w;
        a_gain_q <= gain_bus[in_ch];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld_q  <= 1'b0;
      o_ch_q   <= '0;
      o_data_q <= '0;
    end else begin
      o_vld_q <= a_vld_q;
      if (a_vld_q) begin
        o_ch_q   <= a_ch_q;
        o_data_q <= sat_w;
      end
    end
  end

  assign out_valid = o_vld_q;
  assign out_ch    = o_ch_q;
  assign out_data  = o_data_q;

  // R2: output valid trails the internal stage by one edge
  p_valid_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld_q == $past(a_vld_q));
  // R2: tag carried unchanged through the last stage
  p_tag_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld_q |-> (o_ch_q == $past(a_ch_q)));
endmodule

// File: rtl/ilv_mismatch_corrector.sv
module ilv_mismatch_corrector
  import ilv_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DW      = 12,
  parameter int WIN_LOG = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [$clog2(NUM_CH)-1:0]  in_ch,
  input  logic [DW-1:0]              in_data,
  input  logic                       mode_cont,
  input  logic                       recal,
  output logic                       out_valid,
  output logic [$clog2(NUM_CH)-1:0]  out_ch,
  output logic [DW-1:0]              out_data
);
  localparam int CW = $clog2(NUM_CH);

  logic [1:0]                     rs_q;
  logic                           rst_i;
  logic [NUM_CH-1:0][DW-1:0]      off_bus, amp_bus;
  logic [NUM_CH-1:0][GAIN_W-1:0]  gain_bus;
  logic [NUM_CH-1:0]              win_done, smp_en;
  logic [NUM_CH-1:0][1:0]         done_q, done_d;
  logic                           frozen_q, frozen_d, est_on, all_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign est_on = mode_cont || !frozen_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign smp_en[c] = in_valid && est_on && (in_ch == CW'(c));
      ilv_chan_stats #(.DW(DW), .WIN_LOG(WIN_LOG)) u_stats (
        .clk      (clk),
        .rst_n    (rst_i),
        .smp_en   (smp_en[c]),
        .clr      (recal),
        .smp_x    (in_data),
        .off_est  (off_bus[c]),
        .amp_est  (amp_bus[c]),
        .win_done (win_done[c])
      );
    end
  endgenerate

  always_comb begin
    all_done = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (recal)
        done_d[c] = 2'd0;
      else if (win_done[c] && (done_q[c] != 2'd2))
        done_d[c] = done_q[c] + 2'd1;
      else
        done_d[c] = done_q[c];
      all_done = all_done && done_d[c][1];
    end
    frozen_d = recal ? 1'b0 : (frozen_q || (!mode_cont && all_done));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      done_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      done_q   <= done_d;
      frozen_q <= frozen_d;
    end
  end

  ilv_gain_solver #(.NUM_CH(NUM_CH), .DW(DW)) u_solver (
    .clk      (clk),
    .rst_n    (rst_i),
    .amp_bus  (amp_bus),
    .amp_upd  (win_done),
    .gain_bus (gain_bus)
  );

  ilv_corr_path #(.NUM_CH(NUM_CH), .DW(DW)) u_path (
    .clk       (clk),
    .rst_n     (rst_i),
    .in_valid  (in_valid),
    .in_ch     (in_ch),
    .in_data   (in_data),
    .off_bus   (off_bus),
    .gain_bus  (gain_bus),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_data  (out_data)
  );

  // R3: at most one window closes per cycle
  p_one_window_r3: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(win_done));
  // R8: frozen one-shot estimates do not move
  p_frozen_stable_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (frozen_q && !mode_cont && !recal) |=> ($stable(off_bus) && $stable(amp_bus)));
endmodule

// File: tb/ilv_mismatch_corrector_test.sv
module ilv_mismatch_corrector_test;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int WL  = 3;
  localparam int NV  = 8;
  localparam int VCH [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int VX  [NV] = '{100, -7, 2047, -2048, -1, 0, 555, -900};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, in_valid, mode_cont, recal;
  logic [1:0]    in_ch;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [1:0]    out_ch;
  logic [DW-1:0] out_data;

  ilv_mismatch_corrector #(.NUM_CH(NCH), .DW(DW), .WIN_LOG(WL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .mode_cont(mode_cont), .recal(recal),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data));

  int checks = 0;
  int errors = 0;
  int off_m [NCH];
  int g_m   [NCH];
  int po1 [NCH] = '{0, 10, -20, 5};
  int pa1 [NCH] = '{400, 320, 800, 400};
  int po2 [NCH] = '{0, -30, 40, 0};
  int pa2 [NCH] = '{300, 600, 150, 300};

  logic  drv_chk = 1'b0;
  int    drv_exp = 0;
  string drv_req = "";
  logic  p1_v = 1'b0, p2_v = 1'b0, p1_chk = 1'b0, p2_chk = 1'b0;
  logic [1:0] p1_ch = '0, p2_ch = '0;
  int    p1_exp = 0, p2_exp = 0;
  string p1_req = "", p2_req = "";

  function automatic int model(int c, int x);
    longint d = longint'(x) - longint'(off_m[c]);
    longint s = (d * longint'(g_m[c])) >>> 15;
    if (s > 2047)  return 2047;
    if (s < -2048) return -2048;
    return int'(s);
  endfunction

  task automatic set_model(input int o[NCH], input int a[NCH]);
    for (int c = 0; c < NCH; c++) begin
      off_m[c] = o[c];
      if (c == 0)               g_m[c] = 32768;
      else if (a[0] >= 2*a[c])  g_m[c] = 65535;
      else                      g_m[c] = (a[0] * 32768) / a[c];
    end
  endtask

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // bench-side pipeline mirroring the two-edge latency of R2
  always @(posedge clk) begin
    p2_v <= p1_v; p2_chk <= p1_chk; p2_ch <= p1_ch; p2_exp <= p1_exp; p2_req <= p1_req;
    p1_v <= in_valid; p1_chk <= drv_chk; p1_ch <= in_ch; p1_exp <= drv_exp; p1_req <= drv_req;
  end

  always @(posedge clk) begin
    #5;
    if (p2_chk) begin
      checks++;
      if (p2_v) begin
        if (!(out_valid && out_ch == p2_ch && int'($signed(out_data)) == p2_exp)) begin
          errors++;
          $display("FAIL %s: actual v=%0b ch=%0d data=%0d expected v=1 ch=%0d data=%0d",
                   p2_req, out_valid, out_ch, $signed(out_data), p2_ch, p2_exp);
        end
      end else if (out_valid) begin
        errors++;
        $display("FAIL %s: actual out_valid=1 expected 0", p2_req);
      end
    end
  end

  task automatic send(input int c, input int x, input bit ck, input string rq);
    in_valid = 1'b1;
    in_ch    = 2'(c);
    in_data  = DW'(x);
    drv_chk  = ck;
    drv_exp  = model(c, x);
    drv_req  = rq;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit ck);
    in_valid = 1'b0;
    drv_chk  = ck;
    drv_req  = "R2";
    repeat (n) @(negedge clk);
    drv_chk  = 1'b0;
  endtask

  task automatic feed(input int o[NCH], input int a[NCH], input int r0, input int r1,
                      input bit ck, input string rq);
    for (int r = r0; r < r1; r++)
      for (int c = 0; c < NCH; c++)
        send(c, o[c] + (((r % 2) == 0) ? a[c] : -a[c]), ck, rq);
  endtask

  task automatic probe(input string rq);
    for (int c = 0; c < NCH; c++) begin
      send(c, off_m[c] + 100, 1'b1, rq);
      send(c, off_m[c] + 37, 1'b1, "R5");
      send(c, off_m[c] - 3, 1'b1, "R6");
      send(c, 2047, 1'b1, "R7");
      send(c, -2048, 1'b1, "R7");
    end
  endtask

  task automatic pulse_recal();
    recal = 1'b1;
    @(negedge clk);
    recal = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_ch = '0; in_data = '0; mode_cont = 1'b0; recal = 1'b0;
    for (int c = 0; c < NCH; c++) begin off_m[c] = 0; g_m[c] = 32768; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R1: reset state of the outputs
    check(out_valid == 1'b0, "R2", int'(out_valid), 0);
    check(out_data == '0, "R1", int'($signed(out_data)), 0);

    // R1: table of samples passed through unchanged before any window completes
    for (int i = 0; i < NV; i++) send(VCH[i], VX[i], 1'b1, "R1");
    idle(3, 1'b1);

    // R4 / R5: one-shot calibration on pattern 1
    pulse_recal();
    feed(po1, pa1, 0, 16, 1'b0, "");
    idle(120, 1'b0);
    set_model(po1, pa1);
    probe("R4");

    // R8: frozen, new traffic must not alter the estimates
    feed(po2, pa2, 0, 16, 1'b1, "R8");
    idle(120, 1'b0);
    probe("R8");

    // R9: recalibrate on pattern 2 (includes the 0xFFFF gain clamp on channel 2)
    pulse_recal();
    feed(po2, pa2, 0, 16, 1'b0, "");
    idle(120, 1'b0);
    set_model(po2, pa2);
    probe("R9");

    // R3: continuous mode, incomplete window leaves estimates unchanged
    mode_cont = 1'b1;
    feed(po1, pa1, 0, 7, 1'b1, "R3");
    feed(po1, pa1, 7, 16, 1'b0, "");
    idle(120, 1'b0);
    // R10: continuous estimation followed the new pattern after a freeze
    set_model(po1, pa1);
    probe("R10");
    idle(3, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule